// File: doc/BRIEF.md
# Multi-Channel DMA Register File and Interrupt Logic

This block holds the software-visible registers for each channel of a multi-channel DMA controller and produces the channel interrupt lines. It sits on a simple 32-bit register bus. The channel number comes from the address bits above a 0x2000-byte window. The word offset inside that window selects the register. A read returns its data, or an error flag, one cycle after the request.

Each channel stores the following:
- descriptor and context pointers;
- a configuration word that controls the channel state;
- an interrupt mask;
- a stream-command word.

The channel also keeps raw interrupt causes. The engine sets them, and software clears them through a self-clearing acknowledge register. A status word is built from the channel state, the engine's end-of-list flag and the engine's command-source flag.

Writes to the command and stream-command registers become single-cycle request pulses towards the transfer engine: continue, load descriptor, load context and burst start. When the engine returns a fetched context, its two pointer fields are written into the channel registers.

Top module: `dma_chan_regs`

## Requirements
- R1: The address bits above bit 12 select the channel. An access to a channel number at or above NUM_CH returns rsp_err. A write to one channel never changes another channel. Word offsets (byte offset within the window):
  - data 0x00
  - saved_data 0x58
  - saved_buf 0x5C
  - group 0x60
  - group_down 0x7C
  - cmd 0x80
  - cfg 0x84
  - stat 0x88
  - mask 0x8C
  - ack 0x90
  - intr 0x94
  - masked 0x98
  - scmd 0x9C

  Offsets that are not listed read 0.
- R2: The channel state is coded reset = 1, stopped = 2, running = 4. Reset state is 1. A cfg write with bit 1 set forces stopped. A cfg write with bit 0 clear then forces reset, so reset wins over stopped when both apply. A cfg write with bit 0 set and bit 1 clear leaves the state unchanged.
- R3: stat reads as follows:
  - bits 2:0 hold the state;
  - bit 5 holds the engine end-of-list input;
  - bit 8 holds the engine source input;
  - all other bits are 0.

  After reset, with the source input high, stat reads 0x101.
- R4: Writing ack clears each raw cause bit that is set in the written data (bits INTR_W-1:0). ack always reads 0. A cause set by the engine in the same cycle as an ack of that bit survives. Raw causes stay set until they are acknowledged.
- R5: masked reads intr AND mask. The channel's irq output is high exactly when masked is nonzero. It follows the registers one cycle after a write or a cause.
- R6: Any write to cmd produces a one-cycle continue pulse for that channel, in the cycle after the write. cmd reads back the written value.
- R7: In a scmd write, either of bits 8 or 6 requests a descriptor load. Bit 9 requests a context load. Bit 5 together with a descriptor load requests a burst start. Bit 5 alone produces no pulse. Each request is a one-cycle pulse in the cycle after the write.
- R8: A descriptor-load request copies saved_data into data. A context return from the engine (ctx_vld) writes saved_data and saved_buf, and it wins over a bus write to those registers in the same cycle.
- R9: An access whose byte enables are not all four set returns rsp_err and read data 0, and leaves every register unchanged.
- R10: Writes to stat, intr and masked have no effect.
- R11: scmd stores and reads back only its low 10 bits.
- R12: An engine run report moves the state to running only when cfg bit 0 is set and cfg bit 1 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: channel above bit 12, offset below |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Partial access or absent channel |
| rsp_rdata | output | DW | Read data (0 on error or write) |
| eng_run_i | input | NUM_CH | Engine reports the channel running |
| eng_eol_i | input | NUM_CH | Engine end-of-list flag |
| eng_src_i | input | NUM_CH | Engine command-source flag |
| cause_i | input | NUM_CH*INTR_W | Raw interrupt cause set pulses |
| ctx_vld_i | input | NUM_CH | Engine returns a fetched context |
| ctx_data_i | input | NUM_CH*DW | Context saved-data pointer |
| ctx_buf_i | input | NUM_CH*DW | Context saved-buffer pointer |
| cont_o | output | NUM_CH | Continue request pulse |
| ld_desc_o | output | NUM_CH | Load-descriptor request pulse |
| ld_ctx_o | output | NUM_CH | Load-context request pulse |
| start_o | output | NUM_CH | Burst-start request pulse |
| irq_o | output | NUM_CH | Channel interrupt lines |

## Verification
The bench targets the overlaps in the decoding.

When a cfg write sets both the stop bit and clears the enable bit, the state must become reset. A design that applies the two rules in the wrong order would report stopped instead.

The scmd value 0x240 has to raise both the descriptor and the context pulses. The value 0x020 must raise neither. A decoder that compares whole code values instead of testing bits would get both of these wrong.

An ack that lands in the same cycle as a new cause must keep that cause. A clear-first design would lose the interrupt. Partial-width writes must change nothing, and a design that ignores the byte enables would corrupt the register.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  // word offsets inside one channel window (byte offset / 4)
  localparam logic [5:0] OFS_DATA  = 6'd0;
  localparam logic [5:0] OFS_SDATA = 6'd22;
  localparam logic [5:0] OFS_SBUF  = 6'd23;
  localparam logic [5:0] OFS_GRP   = 6'd24;
  localparam logic [5:0] OFS_GDN   = 6'd31;
  localparam logic [5:0] OFS_CMD   = 6'd32;
  localparam logic [5:0] OFS_CFG   = 6'd33;
  localparam logic [5:0] OFS_STAT  = 6'd34;
  localparam logic [5:0] OFS_MASK  = 6'd35;
  localparam logic [5:0] OFS_ACK   = 6'd36;
  localparam logic [5:0] OFS_INTR  = 6'd37;
  localparam logic [5:0] OFS_MSKD  = 6'd38;
  localparam logic [5:0] OFS_SCMD  = 6'd39;

  localparam int unsigned WIN_BITS = 13;

  typedef enum logic [2:0] {
    ST_RST  = 3'd1,
    ST_STOP = 3'd2,
    ST_RUN  = 3'd4
  } chan_state_e;

  function automatic logic scmd_desc(input logic [9:0] v);
    return v[8] | v[6];
  endfunction

  function automatic logic scmd_ctx(input logic [9:0] v);
    return v[9];
  endfunction

  function automatic logic scmd_start(input logic [9:0] v);
    return scmd_desc(v) & v[5];
  endfunction

  // stop applied first, then disable, so disable has the last word
  function automatic chan_state_e cfg_next(input chan_state_e cur, input logic [1:0] v);
    chan_state_e n;
    n = cur;
    if (v[1])  n = ST_STOP;
    if (!v[0]) n = ST_RST;
    return n;
  endfunction

  function automatic logic [31:0] stat_word(input chan_state_e st, input logic eol,
                                            input logic src);
    logic [31:0] w;
    w      = '0;
    w[2:0] = st;
    w[5]   = eol;
    w[8]   = src;
    return w;
  endfunction

endpackage

// File: rtl/dma_chan_regs_dec.sv
module dma_chan_regs_dec #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [5:0]        off,
  output logic              bad
);
  import dma_chan_regs_pkg::*;
  localparam int unsigned CH_BITS = ADDR_W - WIN_BITS;

  logic [CH_BITS-1:0] ch_idx;
  logic               ch_ok;

  assign ch_idx = addr[ADDR_W-1:WIN_BITS];
  assign ch_ok  = (32'(ch_idx) < NUM_CH);
  assign off    = (addr[WIN_BITS-1:8] == '0) ? addr[7:2] : 6'h3F;
  assign bad    = (be != 4'hF) || !ch_ok;

  always_comb begin
    ch_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      ch_sel[c] = ch_ok && (32'(ch_idx) == c);
  end
endmodule

// File: rtl/dma_chan_regs_ch.sv
module dma_chan_regs_ch #(
  parameter int unsigned DW     = 32,
  parameter int unsigned INTR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        off,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              eng_run_i,
  input  logic              eng_eol_i,
  input  logic              eng_src_i,
  input  logic [INTR_W-1:0] cause_i,
  input  logic              ctx_vld_i,
  input  logic [DW-1:0]     ctx_data_i,
  input  logic [DW-1:0]     ctx_buf_i,
  output logic              cont_o,
  output logic              ld_desc_o,
  output logic              ld_ctx_o,
  output logic              start_o,
  output logic              irq_o,
  output logic [2:0]        state_o,
  output logic [INTR_W-1:0] raw_o,
  output logic [INTR_W-1:0] mask_o
);
  import dma_chan_regs_pkg::*;

  logic [DW-1:0]     r_data, r_sdata, r_sbuf, r_grp, r_gdn, r_cmd, r_cfg;
  logic [9:0]        r_scmd;
  logic [INTR_W-1:0] r_mask, r_raw, ack_bits;
  chan_state_e       state;

  logic wr_data, wr_sdata, wr_sbuf, wr_grp, wr_gdn, wr_cmd, wr_cfg, wr_mask, wr_ack, wr_scmd;
  logic run_ok;

  assign wr_data  = wr_en && off == OFS_DATA;
  assign wr_sdata = wr_en && off == OFS_SDATA;
  assign wr_sbuf  = wr_en && off == OFS_SBUF;
  assign wr_grp   = wr_en && off == OFS_GRP;
  assign wr_gdn   = wr_en && off == OFS_GDN;
  assign wr_cmd   = wr_en && off == OFS_CMD;
  assign wr_cfg   = wr_en && off == OFS_CFG;
  assign wr_mask  = wr_en && off == OFS_MASK;
  assign wr_ack   = wr_en && off == OFS_ACK;
  assign wr_scmd  = wr_en && off == OFS_SCMD;
  assign ack_bits = wr_ack ? wdata[INTR_W-1:0] : '0;
  assign run_ok   = eng_run_i && r_cfg[0] && !r_cfg[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_data <= '0; r_sdata <= '0; r_sbuf <= '0; r_grp <= '0; r_gdn <= '0;
      r_cmd  <= '0; r_cfg   <= '0; r_scmd <= '0; r_mask <= '0; r_raw <= '0;
      state  <= ST_RST;
      cont_o <= 1'b0; ld_desc_o <= 1'b0; ld_ctx_o <= 1'b0; start_o <= 1'b0;
    end else begin
      if (wr_data) r_data <= wdata;
      else if (wr_scmd && scmd_desc(wdata[9:0])) r_data <= r_sdata;
      if (ctx_vld_i) begin
        r_sdata <= ctx_data_i;
        r_sbuf  <= ctx_buf_i;
      end else begin
        if (wr_sdata) r_sdata <= wdata;
        if (wr_sbuf)  r_sbuf  <= wdata;
      end
      if (wr_grp)  r_grp  <= wdata;
      if (wr_gdn)  r_gdn  <= wdata;
      if (wr_cmd)  r_cmd  <= wdata;
      if (wr_cfg)  r_cfg  <= wdata;
      if (wr_mask) r_mask <= wdata[INTR_W-1:0];
      if (wr_scmd) r_scmd <= wdata[9:0];
      r_raw <= (r_raw & ~ack_bits) | cause_i;
      if (wr_cfg)      state <= cfg_next(state, wdata[1:0]);
      else if (run_ok) state <= ST_RUN;
      cont_o    <= wr_cmd;
      ld_desc_o <= wr_scmd && scmd_desc(wdata[9:0]);
      ld_ctx_o  <= wr_scmd && scmd_ctx(wdata[9:0]);
      start_o   <= wr_scmd && scmd_start(wdata[9:0]);
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFS_DATA:  rdata = r_data;
      OFS_SDATA: rdata = r_sdata;
      OFS_SBUF:  rdata = r_sbuf;
      OFS_GRP:   rdata = r_grp;
      OFS_GDN:   rdata = r_gdn;
      OFS_CMD:   rdata = r_cmd;
      OFS_CFG:   rdata = r_cfg;
      OFS_STAT:  rdata = DW'(stat_word(state, eng_eol_i, eng_src_i));
      OFS_MASK:  rdata = DW'(r_mask);
      OFS_INTR:  rdata = DW'(r_raw);
      OFS_MSKD:  rdata = DW'(r_raw & r_mask);
      OFS_SCMD:  rdata = DW'(r_scmd);
      default:   rdata = '0;
    endcase
  end

  assign irq_o   = |(r_raw & r_mask);
  assign state_o = state;
  assign raw_o   = r_raw;
  assign mask_o  = r_mask;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned INTR_W = 4,
  parameter int unsigned ADDR_W = 13 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [3:0]               req_be,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [DW-1:0]            rsp_rdata,
  input  logic [NUM_CH-1:0]        eng_run_i,
  input  logic [NUM_CH-1:0]        eng_eol_i,
  input  logic [NUM_CH-1:0]        eng_src_i,
  input  logic [NUM_CH*INTR_W-1:0] cause_i,
  input  logic [NUM_CH-1:0]        ctx_vld_i,
  input  logic [NUM_CH*DW-1:0]     ctx_data_i,
  input  logic [NUM_CH*DW-1:0]     ctx_buf_i,
  output logic [NUM_CH-1:0]        cont_o,
  output logic [NUM_CH-1:0]        ld_desc_o,
  output logic [NUM_CH-1:0]        ld_ctx_o,
  output logic [NUM_CH-1:0]        start_o,
  output logic [NUM_CH-1:0]        irq_o
);
  logic [NUM_CH-1:0]        ch_sel;
  logic [5:0]               off_w;
  logic                     bad_w;
  logic [NUM_CH-1:0]        wr_en;
  logic [NUM_CH*DW-1:0]     rd_flat;
  logic [NUM_CH*3-1:0]      state_flat;
  logic [NUM_CH*INTR_W-1:0] raw_flat, mask_flat;
  logic [DW-1:0]            rd_sel;

  dma_chan_regs_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .be(req_be), .ch_sel(ch_sel), .off(off_w), .bad(bad_w)
  );

  assign wr_en = (req_valid && req_write && !bad_w) ? ch_sel : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs_ch #(.DW(DW), .INTR_W(INTR_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[c]), .off(off_w), .wdata(req_wdata),
      .rdata(rd_flat[c*DW +: DW]),
      .eng_run_i(eng_run_i[c]), .eng_eol_i(eng_eol_i[c]), .eng_src_i(eng_src_i[c]),
      .cause_i(cause_i[c*INTR_W +: INTR_W]), .ctx_vld_i(ctx_vld_i[c]),
      .ctx_data_i(ctx_data_i[c*DW +: DW]), .ctx_buf_i(ctx_buf_i[c*DW +: DW]),
      .cont_o(cont_o[c]), .ld_desc_o(ld_desc_o[c]), .ld_ctx_o(ld_ctx_o[c]),
      .start_o(start_o[c]), .irq_o(irq_o[c]), .state_o(state_flat[c*3 +: 3]),
      .raw_o(raw_flat[c*INTR_W +: INTR_W]), .mask_o(mask_flat[c*INTR_W +: INTR_W])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_sel[c]) rd_sel = rd_flat[c*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad_w;
      rsp_rdata <= (req_valid && !req_write && !bad_w) ? rd_sel : '0;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned INTR_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [3:0]               req_be,
  input logic [DW-1:0]            req_wdata,
  input logic                     rsp_valid,
  input logic                     rsp_err,
  input logic [NUM_CH-1:0]        wr_en,
  input logic [5:0]               off_w,
  input logic [NUM_CH*3-1:0]      state_flat,
  input logic [NUM_CH*INTR_W-1:0] raw_flat,
  input logic [NUM_CH*INTR_W-1:0] cause_i,
  input logic [NUM_CH-1:0]        irq_o,
  input logic [NUM_CH-1:0]        cont_o,
  input logic [NUM_CH-1:0]        ld_desc_o,
  input logic [NUM_CH-1:0]        start_o
);
  import dma_chan_regs_pkg::*;

  // R9: partial access is refused and writes nothing
  assert_bad_be_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_be != 4'hF) |=> (rsp_valid && rsp_err));
  assert_bad_be_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_be != 4'hF) |-> (wr_en == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_cmd_cont_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && off_w == OFS_CMD) |=> cont_o[c]);
    assert_cfg_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && off_w == OFS_CFG && !req_wdata[0]) |=> (state_flat[c*3 +: 3] == 3'd1));
    assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && off_w == OFS_ACK && req_wdata[INTR_W-1:0] == '1 &&
       cause_i[c*INTR_W +: INTR_W] == '0) |=> !irq_o[c]);
    assert_start_with_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_o[c] |-> ld_desc_o[c]);
    assert_raw_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en[c] && off_w == OFS_ACK) |=>
        ((raw_flat[c*INTR_W +: INTR_W] & $past(raw_flat[c*INTR_W +: INTR_W]))
          == $past(raw_flat[c*INTR_W +: INTR_W])));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .DW(DW), .INTR_W(INTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_be(req_be), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .wr_en(wr_en), .off_w(off_w),
  .state_flat(state_flat), .raw_flat(raw_flat), .cause_i(cause_i), .irq_o(irq_o),
  .cont_o(cont_o), .ld_desc_o(ld_desc_o), .start_o(start_o)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int NCH = 2;
  localparam int AW  = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NCH-1:0] eng_run = '0, eng_eol = '0, eng_src = '1, ctx_vld = '0;
  logic [NCH*4-1:0] cause = '0;
  logic [NCH*32-1:0] ctx_data = '0, ctx_buf = '0;
  logic [NCH-1:0] cont, ldd, ldc, start, irq;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] got;
  logic got_err;
  logic [NCH-1:0] p_cont, p_ldd, p_ldc, p_start;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NCH)) i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .eng_run_i(eng_run), .eng_eol_i(eng_eol), .eng_src_i(eng_src), .cause_i(cause),
    .ctx_vld_i(ctx_vld), .ctx_data_i(ctx_data), .ctx_buf_i(ctx_buf),
    .cont_o(cont), .ld_desc_o(ldd), .ld_ctx_o(ldc), .start_o(start), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ad(input int ch, input int ofs);
    return AW'((ch << 13) | ofs);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF;
    got = rsp_rdata; got_err = rsp_err;
    p_cont = cont; p_ldd = ldd; p_ldc = ldc; p_start = start;
  endtask

  task automatic wr(input int ch, input int ofs, input logic [31:0] d);
    acc(1'b1, ad(ch, ofs), d, 4'hF);
  endtask

  task automatic rd(input int ch, input int ofs);
    acc(1'b0, ad(ch, ofs), 32'h0, 4'hF);
  endtask

  task automatic t_reset;
    rd(0, 'h88); chk("R3 stat after reset", got, 32'h101);
    chk("R5 irq after reset", 32'(irq), 0);
    rd(1, 'h00); chk("R1 data after reset", got, 0);
    rd(0, 'h40); chk("R1 unlisted offset reads 0", got, 0);
  endtask

  task automatic t_regs;
    wr(1, 'h58, 32'hA000_0010); wr(1, 'h60, 32'h1234_5678); wr(1, 'h7C, 32'hCAFE_0000);
    rd(1, 'h58); chk("R1 saved_data ch1", got, 32'hA000_0010);
    rd(1, 'h60); chk("R1 group ch1", got, 32'h1234_5678);
    rd(1, 'h7C); chk("R1 group_down ch1", got, 32'hCAFE_0000);
    rd(0, 'h58); chk("R1 ch0 untouched", got, 0);
  endtask

  task automatic t_state;
    wr(0, 'h84, 32'h1); rd(0, 'h88); chk("R2 enable keeps state", got, 32'h101);
    @(negedge clk) eng_run[0] = 1; @(negedge clk) eng_run[0] = 0;
    rd(0, 'h88); chk("R12 run when enabled", got, 32'h104);
    wr(0, 'h84, 32'h3); rd(0, 'h88); chk("R2 stop bit", got, 32'h102);
    wr(0, 'h84, 32'h2); rd(0, 'h88); chk("R2 reset wins over stop", got, 32'h101);
    @(negedge clk) eng_run[0] = 1; @(negedge clk) eng_run[0] = 0;
    rd(0, 'h88); chk("R12 run ignored when disabled", got, 32'h101);
    eng_eol[0] = 1; eng_src[0] = 0;
    rd(0, 'h88); chk("R3 eol and source fields", got, 32'h021);
    eng_eol[0] = 0; eng_src[0] = 1;
    wr(0, 'h88, 32'hFFFF_FFFF); rd(0, 'h88); chk("R10 stat write ignored", got, 32'h101);
  endtask

  task automatic t_irq;
    wr(0, 'h8C, 32'h4);
    @(negedge clk) cause[3:0] = 4'h4; @(negedge clk) cause[3:0] = 0;
    chk("R5 irq on masked cause", 32'(irq[0]), 1);
    @(negedge clk) cause[3:0] = 4'h1; @(negedge clk) cause[3:0] = 0;
    rd(0, 'h94); chk("R4 raw causes", got, 32'h5);
    rd(0, 'h98); chk("R5 masked", got, 32'h4);
    wr(0, 'h94, 32'h0); rd(0, 'h94); chk("R10 intr write ignored", got, 32'h5);
    wr(0, 'h98, 32'h0); rd(0, 'h98); chk("R10 masked write ignored", got, 32'h4);
    wr(0, 'h90, 32'h4); chk("R5 irq drops after ack", 32'(irq[0]), 0);
    rd(0, 'h94); chk("R4 ack clears only its bits", got, 32'h1);
    rd(0, 'h90); chk("R4 ack reads 0", got, 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = ad(0, 'h90); req_wdata = 32'h4; cause[3:0] = 4'h4;
    @(negedge clk);
    req_valid = 0; req_write = 0; cause[3:0] = 0;
    rd(0, 'h94); chk("R4 same-cycle cause survives ack", got, 32'h5);
    chk("R5 irq kept", 32'(irq[0]), 1);
    wr(0, 'h90, 32'hF); chk("R4 ack all", 32'(irq[0]), 0);
  endtask

  task automatic t_cmd;
    wr(1, 'h80, 32'h1);
    chk("R6 continue pulse ch1 only", 32'(p_cont), 32'h2);
    chk("R6 no stray pulses", 32'({p_ldd, p_ldc, p_start}), 0);
    @(negedge clk) chk("R6 pulse one cycle", 32'(cont), 0);
    rd(1, 'h80); chk("R6 cmd readback", got, 32'h1);
  endtask

  task automatic t_scmd;
    wr(1, 'h9C, 32'h160);
    chk("R7 0x160 load+start", 32'({p_ldd[1], p_start[1], p_ldc[1]}), 32'b110);
    rd(1, 'h00); chk("R8 data gets saved_data", got, 32'hA000_0010);
    wr(1, 'h9C, 32'h140);
    chk("R7 0x140 load no start", 32'({p_ldd[1], p_start[1], p_ldc[1]}), 32'b100);
    wr(1, 'h9C, 32'h020);
    chk("R7 0x020 nothing", 32'({p_ldd[1], p_start[1], p_ldc[1]}), 32'b000);
    wr(1, 'h9C, 32'h200);
    chk("R7 0x200 context only", 32'({p_ldd[1], p_start[1], p_ldc[1]}), 32'b001);
    wr(1, 'h9C, 32'h240);
    chk("R7 0x240 both loads", 32'({p_ldd[1], p_start[1], p_ldc[1]}), 32'b101);
    wr(1, 'h9C, 32'hFFFF_FC20); rd(1, 'h9C); chk("R11 low ten bits", got, 32'h020);
  endtask

  task automatic t_ctx;
    @(negedge clk);
    ctx_vld[1] = 1; ctx_data[63:32] = 32'h0000_1100; ctx_buf[63:32] = 32'h0000_2200;
    req_valid = 1; req_write = 1; req_addr = ad(1, 'h58); req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    ctx_vld[1] = 0; req_valid = 0; req_write = 0;
    rd(1, 'h58); chk("R8 context wins saved_data", got, 32'h0000_1100);
    rd(1, 'h5C); chk("R8 context saved_buf", got, 32'h0000_2200);
  endtask

  task automatic t_err;
    acc(1'b1, ad(1, 'h60), 32'h0, 4'h3);
    chk("R9 partial write error", 32'(got_err), 1);
    rd(1, 'h60); chk("R9 partial write no effect", got, 32'h1234_5678);
    acc(1'b0, ad(1, 'h60), 32'h0, 4'h1);
    chk("R9 partial read error", 32'(got_err), 1);
    chk("R9 partial read data 0", got, 0);
    rd(1, 'h60); chk("R9 full read no error", 32'(got_err), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_regs; t_state; t_irq; t_cmd; t_scmd; t_ctx; t_err;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule